// File: doc/BRIEF.md
# PHY vendor register access controller

This block connects a processor-visible 32-bit control word to an 8-bit PHY link. One write to the control word, with the request bit set, starts a single read or write of one PHY register. A small sequencer then handles the link handshake: it drives the command byte, optionally an extended address byte, and then either the data byte and a stop pulse, or a bus turnaround followed by capture of the returned byte. Busy and done flags in the same word show software how far the access has progressed.

A 6-bit address field selects the PHY register directly. One reserved code, 0x2F, switches to extended addressing, where the real address is the low six bits of a separate byte field. The low nibble of that byte is also driven all the time onto a 4-bit vendor control output. A release bit lets software take the block off the link completely: it drives nothing and ignores what the PHY presents.

Top module: `phy_vreg_ctrl`

## Requirements
- R1: After reset the control word reads 0x00000000. The idle link drives byte 0x00 with output enable 1 and stop 0.
- R2: Control word layout: bit 31 is release, bit 27 is done, bit 26 is busy, bit 25 is request, bit 22 is direction (1 = write), bits 21:16 are the address, bits 15:8 are the extended byte and bits 7:0 are the data. Bits 30:28 and 24:23 read 0, and bit 25 always reads 0. A write made while busy is 0 loads release, direction, address, extended byte and data.
- R3: A write made while busy is 0, with bit 25 = 1 and bit 31 = 0, starts an access. From the next cycle busy reads 1 and done reads 0. Software values written to bits 26 and 27 have no effect.
- R4: Any write made while busy is 1 is ignored in full. The fields, the status and the running link sequence stay unchanged.
- R5: A direct write presents command byte {2'b10, addr} until the PHY asserts next. It then presents the data byte until next, and then gives one cycle with stop = 1 and byte 0x00. In the following cycle busy is 0 and done is 1.
- R6: When addr equals 0x2F, the accepted command byte ({2'b10,6'h2F} for a write, {2'b11,6'h2F} for a read) is followed by byte {2'b00, ext[5:0]}, held until next. After that the write or read continues as in R5 or R7.
- R7: A direct read presents {2'b11, addr} until next, then 0x00. The first cycle in which the PHY direction input is high is a turnaround. The link data input in the cycle after it is stored into bits 7:0. The access finishes in the first later cycle in which direction is low: busy goes to 0 and done to 1.
- R8: If direction goes high while the command byte is presented and before next, the command is withdrawn (0x00 is driven) until direction is low again. The command byte is then presented again. Busy stays 1 and done stays 0 throughout.
- R9: Output enable is 0 in every cycle in which the PHY direction input is high.
- R10: While bit 31 is 1, output enable, stop and the data output are all 0, and the direction, next and data inputs are masked. A request written together with bit 31 = 1 does not start an access.
- R11: The vendor control output always equals bits 11:8 of the control word.
- R12: Done, once set, stays 1 until the next accepted request clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data for the control word |
| reg_rdata | output | 32 | Current control word contents |
| link_data_i | input | 8 | Byte received from the PHY |
| link_data_o | output | 8 | Byte driven to the PHY |
| link_data_oe | output | 1 | Output enable for link_data_o |
| link_dir | input | 1 | PHY owns the data bus when high |
| link_nxt | input | 1 | PHY accepts or presents the current byte |
| link_stp | output | 1 | Stop pulse ending a write |
| vend_ctrl | output | 4 | Vendor control nibble |

## Verification
The access sequencer is driven through a direct write, a direct read, an extended write and an extended read. Between them these separate the two command prefixes, the inserted extended-address byte, and the choice of the capture cycle, since the turnaround cycle carries a decoy byte. Each case is run with and without wait cycles on next, which shows that every byte is held until it is accepted. Further runs cover: a PHY that grabs the bus during the command, which exercises the withdraw-and-retry path; a second request written mid-access; and requests written with the release bit set. These show that busy blocks writes and that release both blocks starts and frees the link.

// File: rtl/phy_vreg_pkg.sv
package phy_vreg_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ADDR_W   = 6;
  localparam int unsigned DRV_BIT  = 31;
  localparam int unsigned DONE_BIT = 27;
  localparam int unsigned BUSY_BIT = 26;
  localparam int unsigned REQ_BIT  = 25;
  localparam int unsigned DIR_BIT  = 22;
  localparam int unsigned ADDR_LSB = 16;
  localparam int unsigned EXT_LSB  = 8;

  typedef struct packed {
    logic              drv_off;
    logic              wr_dir;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] ext;
    logic [BYTE_W-1:0] data;
  } vreg_fields_t;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_CMD, SQ_ABORT, SQ_EXTA, SQ_WDATA,
    SQ_STOP, SQ_RWAIT, SQ_RSAMP, SQ_RREL
  } seq_state_t;

  // Command byte: prefix 2'b10 for a write, 2'b11 for a read.
  function automatic logic [BYTE_W-1:0] cmd_byte(logic is_write, logic [ADDR_W-1:0] a);
    return {1'b1, ~is_write, a};
  endfunction

  function automatic logic [BYTE_W-1:0] ext_byte(logic [ADDR_W-1:0] e);
    return {{(BYTE_W-ADDR_W){1'b0}}, e};
  endfunction

  function automatic logic [REG_W-1:0] pack_status(vreg_fields_t f, logic busy, logic done);
    logic [REG_W-1:0] r;
    r = '0;
    r[DRV_BIT]                = f.drv_off;
    r[DONE_BIT]               = done;
    r[BUSY_BIT]               = busy;
    r[DIR_BIT]                = f.wr_dir;
    r[ADDR_LSB +: ADDR_W]     = f.addr;
    r[EXT_LSB +: BYTE_W]      = f.ext;
    r[BYTE_W-1:0]             = f.data;
    return r;
  endfunction
endpackage

// File: rtl/vreg_regs.sv
module vreg_regs
  import phy_vreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  input  logic              cap_en,
  input  logic [BYTE_W-1:0] cap_data,
  input  logic              fin_evt,
  output vreg_fields_t      fields,
  output logic              busy,
  output logic              done,
  output logic              start_evt
);
  logic wr_ok;
  logic unused_wbits;

  assign wr_ok        = wr_en && !busy;
  assign start_evt    = wr_ok && wdata[REQ_BIT] && !wdata[DRV_BIT];
  assign unused_wbits = ^{wdata[30:26], wdata[24:23]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      if (wr_ok) begin
        fields.drv_off <= wdata[DRV_BIT];
        fields.wr_dir  <= wdata[DIR_BIT];
        fields.addr    <= wdata[ADDR_LSB +: ADDR_W];
        fields.ext     <= wdata[EXT_LSB +: BYTE_W];
        fields.data    <= wdata[BYTE_W-1:0];
      end
      if (cap_en) fields.data <= cap_data;
      if (start_evt) begin
        busy <= 1'b1;
        done <= 1'b0;
      end
      if (fin_evt) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vreg_seq.sv
module vreg_seq
  import phy_vreg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] EXT_MARK = 6'h2F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_dir,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              dir_m,
  input  logic              nxt_m,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              stp_int,
  output logic              cap_en,
  output logic              fin_evt
);
  seq_state_t st, st_n;
  logic is_ext;

  assign is_ext = (addr == EXT_MARK);

  always_comb begin
    st_n    = st;
    tx_byte = '0;
    stp_int = 1'b0;
    cap_en  = 1'b0;
    fin_evt = 1'b0;
    unique case (st)
      SQ_IDLE:  if (start) st_n = SQ_CMD;
      SQ_CMD: begin
        tx_byte = cmd_byte(wr_dir, addr);
        if (dir_m)      st_n = SQ_ABORT;
        else if (nxt_m) st_n = is_ext ? SQ_EXTA : (wr_dir ? SQ_WDATA : SQ_RWAIT);
      end
      SQ_ABORT: if (!dir_m) st_n = SQ_CMD;
      SQ_EXTA: begin
        tx_byte = ext_byte(ext_addr);
        if (nxt_m) st_n = wr_dir ? SQ_WDATA : SQ_RWAIT;
      end
      SQ_WDATA: begin
        tx_byte = wr_data;
        if (nxt_m) st_n = SQ_STOP;
      end
      SQ_STOP: begin
        stp_int = 1'b1;
        fin_evt = 1'b1;
        st_n    = SQ_IDLE;
      end
      SQ_RWAIT: if (dir_m) st_n = SQ_RSAMP;
      SQ_RSAMP: begin
        cap_en = 1'b1;
        st_n   = SQ_RREL;
      end
      SQ_RREL: if (!dir_m) begin
        fin_evt = 1'b1;
        st_n    = SQ_IDLE;
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SQ_IDLE;
    else        st <= st_n;
  end
endmodule

// File: rtl/vreg_link.sv
module vreg_link
  import phy_vreg_pkg::*;
(
  input  logic              drv_off,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              stp_int,
  input  logic [BYTE_W-1:0] pin_data_i,
  input  logic              pin_dir,
  input  logic              pin_nxt,
  output logic [BYTE_W-1:0] pin_data_o,
  output logic              pin_oe,
  output logic              pin_stp,
  output logic [BYTE_W-1:0] data_m,
  output logic              dir_m,
  output logic              nxt_m
);
  assign pin_data_o = drv_off ? '0 : tx_byte;
  assign pin_oe     = !drv_off && !pin_dir;
  assign pin_stp    = !drv_off && stp_int;
  assign data_m     = drv_off ? '0 : pin_data_i;
  assign dir_m      = !drv_off && pin_dir;
  assign nxt_m      = !drv_off && pin_nxt;
endmodule

// File: rtl/phy_vreg_ctrl.sv
module phy_vreg_ctrl
  import phy_vreg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] EXT_MARK = 6'h2F,
  parameter int unsigned       VC_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [BYTE_W-1:0] link_data_i,
  output logic [BYTE_W-1:0] link_data_o,
  output logic              link_data_oe,
  input  logic              link_dir,
  input  logic              link_nxt,
  output logic              link_stp,
  output logic [VC_W-1:0]   vend_ctrl
);
  vreg_fields_t      fields;
  logic              busy, done;
  logic              start_evt, fin_evt, cap_en;
  logic              dir_m, nxt_m, stp_int;
  logic [BYTE_W-1:0] data_m, tx_byte;

  vreg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wdata(reg_wdata),
    .cap_en(cap_en), .cap_data(data_m), .fin_evt(fin_evt),
    .fields(fields), .busy(busy), .done(done), .start_evt(start_evt)
  );

  vreg_seq #(.EXT_MARK(EXT_MARK)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .wr_dir(fields.wr_dir),
    .addr(fields.addr), .ext_addr(fields.ext[ADDR_W-1:0]), .wr_data(fields.data),
    .dir_m(dir_m), .nxt_m(nxt_m), .tx_byte(tx_byte), .stp_int(stp_int),
    .cap_en(cap_en), .fin_evt(fin_evt)
  );

  vreg_link u_link (
    .drv_off(fields.drv_off), .tx_byte(tx_byte), .stp_int(stp_int),
    .pin_data_i(link_data_i), .pin_dir(link_dir), .pin_nxt(link_nxt),
    .pin_data_o(link_data_o), .pin_oe(link_data_oe), .pin_stp(link_stp),
    .data_m(data_m), .dir_m(dir_m), .nxt_m(nxt_m)
  );

  assign reg_rdata = pack_status(fields, busy, done);
  assign vend_ctrl = fields.ext[VC_W-1:0];
endmodule

// File: rtl/phy_vreg_chk.sv
module phy_vreg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_en,
  input logic [31:0] reg_rdata,
  input logic [7:0]  link_data_o,
  input logic        link_data_oe,
  input logic        link_dir,
  input logic        link_stp,
  input logic [3:0]  vend_ctrl,
  input logic        start_evt,
  input logic        fin_evt
);
  logic unused_chk;
  assign unused_chk = ^{reg_rdata[30:28], reg_rdata[25:12], reg_rdata[7:0]};

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (reg_rdata[26] && !reg_rdata[27]));

  assert_busy_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_rdata[26]) |-> !start_evt);

  assert_stop_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    link_stp |=> (!reg_rdata[26] && reg_rdata[27]));

  assert_fin_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt |=> (reg_rdata[27] && !reg_rdata[26]));

  assert_no_drive_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
    link_dir |-> !link_data_oe);

  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31] |-> (!link_data_oe && !link_stp && link_data_o == 8'h00));

  assert_vend_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vend_ctrl == reg_rdata[11:8]);

  assert_done_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[27] && !start_evt) |=> reg_rdata[27]);
endmodule

bind phy_vreg_ctrl phy_vreg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rdata(reg_rdata),
  .link_data_o(link_data_o), .link_data_oe(link_data_oe), .link_dir(link_dir),
  .link_stp(link_stp), .vend_ctrl(vend_ctrl), .start_evt(start_evt), .fin_evt(fin_evt)
);

// File: tb/sim_phy_vreg_ctrl.sv
`timescale 1ns/1ps
module sim_phy_vreg_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  link_data_i = '0;
  logic [7:0]  link_data_o;
  logic        link_data_oe;
  logic        link_dir = 1'b0;
  logic        link_nxt = 1'b0;
  logic        link_stp;
  logic [3:0]  vend_ctrl;

  phy_vreg_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .link_data_i(link_data_i), .link_data_o(link_data_o),
    .link_data_oe(link_data_oe), .link_dir(link_dir), .link_nxt(link_nxt),
    .link_stp(link_stp), .vend_ctrl(vend_ctrl)
  );

  always #4 clk = ~clk;

  // Reference model state
  logic       e_drv = 0, e_done = 0, e_busy = 0, e_dir = 0, e_stp = 0;
  logic [5:0] e_addr = 0;
  logic [7:0] e_ext = 0, e_data = 0, e_do = 0;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit chk_on = 0, ended = 0;
  string cur_req = "R1";

  function automatic logic [31:0] model_word();
    logic [31:0] w;
    w = 32'h0;
    w = w | (32'(e_drv) << 31) | (32'(e_done) << 27) | (32'(e_busy) << 26);
    w = w | (32'(e_dir) << 22) | (32'(e_addr) << 16) | (32'(e_ext) << 8) | 32'(e_data);
    return w;
  endfunction

  function automatic logic [31:0] mk(bit drv, bit req, bit wr, logic [5:0] a,
                                     logic [7:0] x, logic [7:0] d);
    return (32'(drv) << 31) | (32'(req) << 25) | (32'(wr) << 22) |
           (32'(a) << 16) | (32'(x) << 8) | 32'(d);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: got %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // Compare everything on every clock, away from the active edge
  always @(negedge clk) if (chk_on && !ended) begin
    check({cur_req, " word"}, reg_rdata, model_word());
    check({cur_req, " data_o"}, 32'(link_data_o), 32'(e_do));
    check({cur_req, " stp"}, 32'(link_stp), 32'(e_stp));
    check({cur_req, " oe R9"}, 32'(link_data_oe), 32'(!e_drv && !link_dir));
    check({cur_req, " vend R11"}, 32'(vend_ctrl), 32'(e_ext[3:0]));
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic cpu_write(logic [31:0] w);
    reg_wr_en = 1'b1;
    reg_wdata = w;
    step();
    reg_wr_en = 1'b0;
    if (!e_busy) begin
      e_drv = w[31]; e_dir = w[22]; e_addr = w[21:16]; e_ext = w[15:8]; e_data = w[7:0];
      if (w[25] && !w[31]) begin
        e_busy = 1; e_done = 0;
        e_do = {1'b1, !e_dir, e_addr};
      end
    end
  endtask

  task automatic wr_finish(int nwait);
    for (int i = 0; i < nwait; i++) step();
    link_nxt = 1; step();
    if (e_addr == 6'h2F) begin e_do = {2'b00, e_ext[5:0]}; step(); end
    e_do = e_data; step();
    e_do = 8'h00; e_stp = 1; link_nxt = 0; step();
    e_stp = 0; e_busy = 0; e_done = 1;
  endtask

  task automatic rd_finish(int nwait, logic [7:0] val);
    for (int i = 0; i < nwait; i++) step();
    link_nxt = 1; step();
    if (e_addr == 6'h2F) begin e_do = {2'b00, e_ext[5:0]}; step(); end
    e_do = 8'h00; link_nxt = 0; link_dir = 1; link_data_i = 8'hEE; step();
    link_data_i = val; step();
    e_data = val; link_dir = 0; link_data_i = 8'h33; step();
    e_busy = 0; e_done = 1;
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    step(); chk_on = 1; step();
    rst_n = 1; step(); step();

    // R2 and R3: field load, status bits not writable, reserved bits read 0
    cur_req = "R2 R3";
    cpu_write(32'h7C00_0000 | mk(0, 0, 1, 6'h05, 8'hA7, 8'h3C));
    step();

    // R5: direct write with three wait cycles on next
    cur_req = "R5";
    cpu_write(mk(0, 1, 1, 6'h12, 8'h09, 8'h5A));
    wr_finish(3);
    // R12: done holds while idle
    cur_req = "R12";
    repeat (4) step();

    // R7: direct read, done cleared by the new request (R12)
    cur_req = "R7 R12";
    cpu_write(mk(0, 1, 0, 6'h0A, 8'h02, 8'h00));
    rd_finish(1, 8'hC3);
    step();

    // R6: extended write, then extended read
    cur_req = "R6 write";
    cpu_write(mk(0, 1, 1, 6'h2F, 8'hD5, 8'h81));
    wr_finish(0);
    step();
    cur_req = "R6 read";
    cpu_write(mk(0, 1, 0, 6'h2F, 8'h6B, 8'h00));
    rd_finish(2, 8'h4E);
    step();

    // R8 and R9: PHY takes the bus during the command
    cur_req = "R8 R9";
    cpu_write(mk(0, 1, 1, 6'h21, 8'h00, 8'hF0));
    link_dir = 1; step();
    e_do = 8'h00; step();
    step();
    link_dir = 0; step();
    e_do = {2'b10, e_addr};
    wr_finish(1);
    step();

    // R4: a write while busy is ignored
    cur_req = "R4";
    cpu_write(mk(0, 1, 1, 6'h07, 8'h0C, 8'h99));
    cpu_write(32'h8000_0000 | mk(0, 1, 0, 6'h2F, 8'hFF, 8'h11));
    wr_finish(1);
    step();

    // R10: release blocks a request and frees the link
    cur_req = "R10";
    cpu_write(mk(1, 1, 1, 6'h03, 8'h04, 8'h77));
    link_dir = 1; link_nxt = 1; link_data_i = 8'h5C;
    step(); step(); step();
    link_dir = 0; link_nxt = 0; step();
    cur_req = "R10 exit";
    cpu_write(mk(0, 1, 0, 6'h03, 8'h04, 8'h00));
    rd_finish(0, 8'h96);
    repeat (3) step();

    finish_run();
  end
endmodule